// File: doc/BRIEF.md
# Arbitrary-Ratio Stream Width Gearbox

This block repacks a valid/ready/last stream of `IN_W`-bit beats into a stream of `OUT_W`-bit beats. The two widths are free parameters. One may be a multiple of the other, or neither may divide the other. Bits keep their order. The least significant bit of each input beat is taken first, and each output word is filled from its least significant bit upward.

Incoming bits land in a bit-addressed ring of `IN_W + OUT_W` cells. The ring has separate write and read pointers and a fill count. A single output register follows the ring and holds one word for the downstream side. A beat marked last tells the block to drain everything it holds. Whole words go out first. The final word leaves with `out_last` set, and it may be short. Its bits above the fill level are not cleared. After that word the ring starts again at cell zero, so each packet begins aligned.

Top module: `stream_gearbox`

## Requirements
- R1: For integer ratios (for example 32 to 8 and 8 to 32), the output bit stream equals the input bit stream, with bit 0 of each input beat taken first and each output word filled from its bit 0 upward.
- R2: The same bit-exact ordering holds when neither width divides the other (for example 24 to 16 and 16 to 24).
- R3: After a beat with `in_last` = 1 is accepted, the remaining buffered bits leave as output words. The final one carries `out_last` = 1, even when it holds fewer than `OUT_W` valid bits. Only its low valid bits are defined.
- R4: When `IN_W` > `OUT_W`, `out_last` is 1 only on the final word cut from the last beat. Every earlier word of that beat has `out_last` = 0.
- R5: The first bit of the packet that follows a flush appears at bit 0 of the next output word, and the ring is empty in the cycle after the flush word leaves it.
- R6: In the cycle after a beat with `in_last` = 1 is accepted, `in_ready` is 0. It stays 0 until the flush word has left the ring. `in_ready` depends only on registered state, and the ring never holds more than `IN_W + OUT_W` bits.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data` and `out_last` do not change.
- R8: After reset, `out_valid` = 0 and `in_ready` = 1. The parameter `RST_KIND` selects a synchronous or an asynchronous active-low reset.
- R9: With `out_ready` held at 1 and input offered on every cycle, a 32-to-8 gearbox delivers one word in every cycle from the first word to the last, with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_data | input | IN_W | Input beat data |
| in_valid | input | 1 | Input beat offered |
| in_last | input | 1 | Input beat ends the packet and forces a flush |
| in_ready | output | 1 | Block can take an input beat |
| out_data | output | OUT_W | Output word data |
| out_valid | output | 1 | Output word available |
| out_last | output | 1 | Output word ends the packet |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
In one cycle the ring can be written with a new beat while it hands a word to the output register. In that same cycle the output register may be emptied by downstream and refilled. A back-to-back 32-to-8 burst with `out_ready` held high provokes this. The fill level then sits at `OUT_W` when the next beat arrives. A single lost or repeated bit would break the scoreboard's bit stream, and a missed overlap would show up as a gap in the one-word-per-cycle count.

A second overlap comes from the flush. A last beat with random stalls puts the short final word into the output register while the prior word is still draining. There the scoreboard judges only the low valid bits of that word, together with `out_last`.

// File: rtl/gearbox_pkg.sv
package gearbox_pkg;

    // Reset flavour for every register in the gearbox
    typedef enum logic {
        RST_SYNC  = 1'b0,
        RST_ASYNC = 1'b1
    } rst_kind_e;

    // Wrap a position that is below twice the ring span back into the ring
    function automatic int unsigned ring_wrap(int unsigned pos, int unsigned span);
        return (pos >= span) ? pos - span : pos;
    endfunction

endpackage

// File: rtl/gearbox_ring.sv
module gearbox_ring
    import gearbox_pkg::*;
#(
    parameter int        IN_W     = 32,
    parameter int        OUT_W    = 8,
    parameter rst_kind_e RST_KIND = RST_SYNC,
    localparam int       BUF_W    = IN_W + OUT_W,
    localparam int       PTR_W    = $clog2(BUF_W),
    localparam int       FILL_W   = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   wr_data,
    input  logic              wr_valid,
    input  logic              wr_last,
    output logic              wr_ready,
    output logic [OUT_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    input  logic              rd_ready,
    output logic [FILL_W-1:0] fill
);

    typedef struct packed {
        logic [BUF_W-1:0]  bits;
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [FILL_W-1:0] fill;
        logic              flush_pend;
    } ring_t;

    ring_t cur_q;
    ring_t nxt_d;
    logic  wr_fire;
    logic  rd_fire;

    function automatic logic [PTR_W-1:0] slot(logic [PTR_W-1:0] base, int unsigned off);
        return PTR_W'(ring_wrap(32'(base) + off, BUF_W));
    endfunction

    // Handshake terms come from registered state only
    assign wr_ready = !cur_q.flush_pend && (cur_q.fill <= FILL_W'(OUT_W));
    assign rd_valid = (cur_q.fill >= FILL_W'(OUT_W)) ||
                      (cur_q.flush_pend && (cur_q.fill != '0));
    assign rd_last  = cur_q.flush_pend && (cur_q.fill <= FILL_W'(OUT_W));
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;
    assign fill     = cur_q.fill;

    // Read window: OUT_W cells starting at the read pointer
    always_comb begin
        for (int unsigned j = 0; j < OUT_W; j++) begin
            rd_data[j] = cur_q.bits[slot(cur_q.rd_ptr, j)];
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (wr_fire) begin
            for (int unsigned i = 0; i < IN_W; i++) begin
                nxt_d.bits[slot(cur_q.wr_ptr, i)] = wr_data[i];
            end
        end
        if (rd_fire && rd_last) begin
            // Flush word taken: realign the next packet at cell zero
            nxt_d.wr_ptr     = '0;
            nxt_d.rd_ptr     = '0;
            nxt_d.fill       = '0;
            nxt_d.flush_pend = 1'b0;
        end else begin
            if (wr_fire) begin
                nxt_d.wr_ptr     = slot(cur_q.wr_ptr, IN_W);
                nxt_d.flush_pend = wr_last;
            end
            if (rd_fire) begin
                nxt_d.rd_ptr = slot(cur_q.rd_ptr, OUT_W);
            end
            nxt_d.fill = cur_q.fill
                       + (wr_fire ? FILL_W'(IN_W)  : '0)
                       - (rd_fire ? FILL_W'(OUT_W) : '0);
        end
    end

    generate
        if (RST_KIND == RST_ASYNC) begin : g_arst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cur_q <= '0;
                else        cur_q <= nxt_d;
            end
        end else begin : g_srst
            always_ff @(posedge clk) begin
                if (!rst_n) cur_q <= '0;
                else        cur_q <= nxt_d;
            end
        end
    endgenerate

endmodule

// File: rtl/gearbox_outreg.sv
module gearbox_outreg
    import gearbox_pkg::*;
#(
    parameter int        OUT_W    = 8,
    parameter rst_kind_e RST_KIND = RST_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] ld_data,
    input  logic             ld_valid,
    input  logic             ld_last,
    output logic             ld_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready
);

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic             valid;
        logic             last;
    } oreg_t;

    oreg_t cur_q;
    oreg_t nxt_d;

    // Free when empty or being drained in this cycle
    assign ld_ready  = !cur_q.valid || out_ready;
    assign out_data  = cur_q.data;
    assign out_valid = cur_q.valid;
    assign out_last  = cur_q.last;

    always_comb begin
        nxt_d = cur_q;
        if (ld_valid && ld_ready) begin
            nxt_d.data  = ld_data;
            nxt_d.valid = 1'b1;
            nxt_d.last  = ld_last;
        end else if (out_ready) begin
            nxt_d.valid = 1'b0;
        end
    end

    generate
        if (RST_KIND == RST_ASYNC) begin : g_arst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cur_q <= '0;
                else        cur_q <= nxt_d;
            end
        end else begin : g_srst
            always_ff @(posedge clk) begin
                if (!rst_n) cur_q <= '0;
                else        cur_q <= nxt_d;
            end
        end
    endgenerate

endmodule

// File: rtl/stream_gearbox.sv
module stream_gearbox
    import gearbox_pkg::*;
#(
    parameter int        IN_W     = 32,
    parameter int        OUT_W    = 8,
    parameter rst_kind_e RST_KIND = RST_SYNC,
    localparam int       FILL_W   = $clog2(IN_W + OUT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready
);

    logic [OUT_W-1:0]  ring_data;
    logic              ring_valid;
    logic              ring_last;
    logic              ring_ready;
    logic [FILL_W-1:0] ring_fill;
    logic              ring_pop;
    logic              ring_pop_last;

    gearbox_ring #(
        .IN_W     (IN_W),
        .OUT_W    (OUT_W),
        .RST_KIND (RST_KIND)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (in_data),
        .wr_valid (in_valid),
        .wr_last  (in_last),
        .wr_ready (in_ready),
        .rd_data  (ring_data),
        .rd_valid (ring_valid),
        .rd_last  (ring_last),
        .rd_ready (ring_ready),
        .fill     (ring_fill)
    );

    gearbox_outreg #(
        .OUT_W    (OUT_W),
        .RST_KIND (RST_KIND)
    ) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_data   (ring_data),
        .ld_valid  (ring_valid),
        .ld_last   (ring_last),
        .ld_ready  (ring_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    assign ring_pop      = ring_valid && ring_ready;
    assign ring_pop_last = ring_last;

endmodule

// File: rtl/gearbox_checker.sv
module gearbox_checker #(
    parameter int  IN_W   = 32,
    parameter int  OUT_W  = 8,
    localparam int BUF_W  = IN_W + OUT_W,
    localparam int FILL_W = $clog2(BUF_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic [OUT_W-1:0]  out_data,
    input logic              out_valid,
    input logic              out_last,
    input logic              out_ready,
    input logic [FILL_W-1:0] ring_fill,
    input logic              ring_pop,
    input logic              ring_pop_last
);

    // R6
    ready_drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_fill <= FILL_W'(BUF_W));

    // R5
    flush_empties_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_pop && ring_pop_last) |=> (ring_fill == '0));

    // R3
    flush_word_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_pop && ring_pop_last) |=> (out_valid && out_last));

    // R7
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind stream_gearbox gearbox_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_last       (in_last),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_last      (out_last),
    .out_ready     (out_ready),
    .ring_fill     (ring_fill),
    .ring_pop      (ring_pop),
    .ring_pop_last (ring_pop_last)
);

// File: tb/stream_gearbox_test.sv
`timescale 1ns/1ps

module gearbox_lane #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 8,
    parameter int PKTS  = 50,
    parameter bit BURST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output int   checks,
    output int   errors,
    output logic done
);

    localparam int  BURST_BEATS = 8;
    localparam int  BURST_WORDS = BURST_BEATS * IN_W / OUT_W;
    localparam bit  ODD_RATIO   = (IN_W % OUT_W != 0) && (OUT_W % IN_W != 0);

    logic [IN_W-1:0]  in_data;
    logic             in_valid;
    logic             in_last;
    logic             in_ready;
    logic [OUT_W-1:0] out_data;
    logic             out_valid;
    logic             out_last;
    logic             out_ready;

    stream_gearbox #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    // Scoreboard queues
    logic [OUT_W-1:0] exp_data[$];
    int               exp_nb[$];
    bit               exp_last[$];
    string            exp_tag[$];

    int  drv_checks = 0, drv_errs = 0, mon_checks = 0, mon_errs = 0;
    bit  burst_mode = 1'b0;
    bit  prev_partial = 1'b0;
    logic [IN_W-1:0] beats[$];

    assign checks = drv_checks + mon_checks;
    assign errors = drv_errs + mon_errs;

    task automatic plan_packet(input bit has_last, input string base_tag);
        bit               bq[$];
        logic [OUT_W-1:0] w;
        int               n;
        bit               first;
        bit               lst;
        string            tag;
        foreach (beats[b]) for (int k = 0; k < IN_W; k++) bq.push_back(beats[b][k]);
        first = 1'b1;
        n = 0;
        while (bq.size() > 0) begin
            n = (bq.size() < OUT_W) ? bq.size() : OUT_W;
            w = '0;
            for (int k = 0; k < n; k++) w[k] = bq.pop_front();
            lst = has_last && (bq.size() == 0);
            tag = base_tag;
            if (lst && n < OUT_W)             tag = "R3";
            else if (lst && IN_W > OUT_W)     tag = "R4";
            else if (first && prev_partial)   tag = "R5";
            exp_data.push_back(w);
            exp_nb.push_back(n);
            exp_last.push_back(lst);
            exp_tag.push_back(tag);
            first = 1'b0;
        end
        prev_partial = has_last && (n < OUT_W);
    endtask

    task automatic send_beat(input logic [IN_W-1:0] d, input logic l, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
        end
        in_data  = d;
        in_last  = l;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (l) begin
            @(negedge clk);
            drv_checks++;
            if (in_ready !== 1'b0) begin
                drv_errs++;
                $display("FAIL R6 in_ready after last beat: actual %b expected 0", in_ready);
            end
            @(posedge clk); #1;
        end
    endtask

    // Downstream ready pattern
    always @(posedge clk) begin
        #1;
        out_ready = burst_mode ? 1'b1 : (($urandom % 4) != 0);
    end

    initial begin
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
        out_ready = 1'b0;
        done     = 1'b0;
        wait (rst_n === 1'b1);
        @(negedge clk);
        drv_checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            drv_errs++;
            $display("FAIL R8 reset state: actual valid=%b ready=%b expected valid=0 ready=1",
                     out_valid, in_ready);
        end
        @(posedge clk); #1;
        if (BURST) begin
            burst_mode = 1'b1;
            @(posedge clk); #1;
            beats.delete();
            for (int b = 0; b < BURST_BEATS; b++) beats.push_back(IN_W'($urandom));
            plan_packet(1'b0, "R9");
            for (int b = 0; b < BURST_BEATS; b++) send_beat(beats[b], 1'b0, 0);
            wait (exp_data.size() == 0);
            @(posedge clk); #1;
            burst_mode = 1'b0;
        end
        for (int p = 0; p < PKTS; p++) begin
            int nb;
            nb = 1 + ($urandom % 6);
            beats.delete();
            for (int b = 0; b < nb; b++) beats.push_back(IN_W'($urandom));
            plan_packet(1'b1, ODD_RATIO ? "R2" : "R1");
            for (int b = 0; b < nb; b++) send_beat(beats[b], b == nb - 1, $urandom % 3);
        end
        wait (exp_data.size() == 0);
        repeat (4) @(posedge clk);
        done = 1'b1;
    end

    // Monitor: compare words as they are taken
    logic [OUT_W-1:0] mask;
    logic [OUT_W-1:0] hold_data;
    logic             hold_last;
    bit               stall_prev = 1'b0;
    int               cyc = 0;
    int               burst_first = 0;
    int               burst_seen = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (stall_prev) begin
                mon_checks++;
                if (out_valid !== 1'b1 || out_data !== hold_data || out_last !== hold_last) begin
                    mon_errs++;
                    $display("FAIL R7 stalled word changed: actual %h/%b expected %h/%b",
                             out_data, out_last, hold_data, hold_last);
                end
            end
            stall_prev = out_valid && !out_ready;
            hold_data  = out_data;
            hold_last  = out_last;
            if (out_valid && out_ready) begin
                if (exp_data.size() == 0) begin
                    mon_checks++;
                    mon_errs++;
                    $display("FAIL R1 unexpected word: actual %h expected none", out_data);
                end else begin
                    logic [OUT_W-1:0] ed;
                    int               en;
                    bit               el;
                    string            et;
                    ed = exp_data.pop_front();
                    en = exp_nb.pop_front();
                    el = exp_last.pop_front();
                    et = exp_tag.pop_front();
                    mask = '0;
                    for (int k = 0; k < en; k++) mask[k] = 1'b1;
                    mon_checks += 2;
                    if (((out_data ^ ed) & mask) != '0) begin
                        mon_errs++;
                        $display("FAIL %s data (%0d valid bits): actual %h expected %h",
                                 et, en, out_data & mask, ed);
                    end
                    if (out_last !== el) begin
                        mon_errs++;
                        $display("FAIL %s last flag: actual %b expected %b", et, out_last, el);
                    end
                    if (et == "R9") begin
                        if (burst_seen == 0) burst_first = cyc;
                        burst_seen++;
                        if (burst_seen == BURST_WORDS) begin
                            mon_checks++;
                            if (cyc - burst_first + 1 != BURST_WORDS) begin
                                mon_errs++;
                                $display("FAIL R9 burst cycles: actual %0d expected %0d",
                                         cyc - burst_first + 1, BURST_WORDS);
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

module stream_gearbox_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    always #2 clk = ~clk;

    int   c0, c1, c2, c3, e0, e1, e2, e3;
    logic d0, d1, d2, d3;

    gearbox_lane #(.IN_W(32), .OUT_W(8),  .BURST(1'b1)) lane_a (
        .clk(clk), .rst_n(rst_n), .checks(c0), .errors(e0), .done(d0));
    gearbox_lane #(.IN_W(8),  .OUT_W(32)) lane_b (
        .clk(clk), .rst_n(rst_n), .checks(c1), .errors(e1), .done(d1));
    gearbox_lane #(.IN_W(24), .OUT_W(16)) lane_c (
        .clk(clk), .rst_n(rst_n), .checks(c2), .errors(e2), .done(d2));
    gearbox_lane #(.IN_W(16), .OUT_W(24)) lane_d (
        .clk(clk), .rst_n(rst_n), .checks(c3), .errors(e3), .done(d3));

    initial begin
        int  wd_err;
        bit  finished;
        wd_err   = 0;
        finished = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (d0 && d1 && d2 && d3) begin
                finished = 1'b1;
                break;
            end
        end
        if (!finished) begin
            wd_err = 1;
            $display("FAIL R1 watchdog expired: actual running expected all lanes done");
        end
        #1;
        $display("  CHECKS %0d ERRORS %0d", c0 + c1 + c2 + c3 + wd_err,
                 e0 + e1 + e2 + e3 + wd_err);
        $finish;
    end

endmodule